// File: doc/BRIEF.md
# Four-Way Set-Associative Tag Lookup

This block is the tag-check and word-select stage of a set-associative cache holding one 32-bit word per block. A 32-bit byte address picks one of 256 sets, and the block reads the valid flag, tag and word of all four ways in that set. It compares the four stored tags with the address tag in parallel. It then reports a hit, the number of the matching way and that way's word, one clock after the request.

A second port installs blocks. A fill writes a tag and a word into one way of the addressed set. If that tag is already present in the set, only the word of that way is replaced. Otherwise the block uses the lowest-numbered empty way. When all four ways are occupied, a round-robin pointer kept for each set picks the victim. Requests to memory on a miss are handled elsewhere.

Top module: `sa4_lookup`

## Requirements
- R1: While reset is low, and on the cycles after it is released, rsp_valid is 0. Reset empties every way of every set, so the first lookups after reset miss.
- R2: A lookup presented with lk_valid=1 is answered on the next clock edge with rsp_valid=1. If a valid way of the set holds the address tag, the answer has rsp_hit=1, rsp_way set to the binary number of that way (0 to 3) and rsp_data set to that way's word.
- R3: A lookup that finds no valid way holding the tag answers with rsp_hit=0, rsp_way=0 and rsp_data=0.
- R4: Address bits 1..0 take no part in lookup or fill. Addresses that differ only in those bits give identical results.
- R5: The set is chosen by address bits 9..2 and the tag is address bits 31..10. A tag installed in one set does not hit in any other set.
- R6: A fill whose tag is absent from the set, while at least one way of the set is empty, writes the lowest-numbered empty way.
- R7: A fill whose tag is absent from a full set writes the way named by that set's 2-bit pointer. The pointer then advances by one, modulo 4. Each set has its own pointer, and reset sets every pointer to 0.
- R8: A fill whose tag is already valid in the set rewrites the word of that way only. It neither takes another way nor moves the pointer.
- R9: A lookup and a fill in the same cycle are both served. The lookup answer reflects the set contents from before the fill.
- R10: No lookup ever finds more than one matching way.
- R11: A cycle without lk_valid produces rsp_valid=0, rsp_hit=0 and a zero answer on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | 32 | Fill byte address |
| fill_data | input | 32 | Word to install |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Answer is a hit |
| rsp_way | output | 2 | Matching way number |
| rsp_data | output | 32 | Word from the matching way |

## Verification
A lookup and a fill can land in the same cycle, and their order then decides what the lookup sees. The bench drives both ports together, once with the lookup and the fill on the same address, which must give a miss followed by a hit, and throughout a long random phase on a small pool of sets and tags. The behavioural model always answers the lookup from the set contents before applying the fill, and it compares every answer field on every clock. A fill that replaces a resident tag in a full set, followed at once by a lookup of the evicted tag, checks pointer advance and eviction together.

// File: rtl/sa4_pkg.sv
package sa4_pkg;

    localparam int unsigned SA4_ADDR_W = 32;
    localparam int unsigned SA4_DATA_W = 32;
    localparam int unsigned SA4_SETS   = 256;
    localparam int unsigned SA4_WAYS   = 4;
    localparam int unsigned SA4_OFF_W  = 2;

endpackage

// File: rtl/sa4_tag_cmp.sv
module sa4_tag_cmp #(
    parameter int unsigned TAG_W = 22
) (
    input  logic             way_valid,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             match
);

    always_comb begin
        match = way_valid && (stored_tag == probe_tag);
    end

endmodule

// File: rtl/sa4_way_sel.sv
module sa4_way_sel #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             match,
    input  logic [WAYS-1:0][DATA_W-1:0] way_data,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [DATA_W-1:0]           hit_data
);

    // AND-OR select: a one-hot match steers exactly one word.
    always_comb begin
        hit      = |match;
        hit_way  = '0;
        hit_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_data = hit_data | ({DATA_W{match[w]}} & way_data[w]);
            hit_way  = hit_way  | ({WAY_W{match[w]}} & WAY_W'(w));
        end
    end

endmodule

// File: rtl/sa4_victim.sv
module sa4_victim #(
    parameter int unsigned WAYS = 4,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  set_valid,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim,
    output logic             from_rr
);

    logic [WAY_W-1:0] first_free;

    // Walk from the top so the lowest empty way wins.
    always_comb begin
        first_free = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                first_free = WAY_W'(w);
            end
        end
        from_rr = &set_valid;
        victim  = from_rr ? rr_ptr : first_free;
    end

endmodule

// File: rtl/sa4_lookup.sv
module sa4_lookup
    import sa4_pkg::*;
#(
    parameter int unsigned ADDR_W = SA4_ADDR_W,
    parameter int unsigned DATA_W = SA4_DATA_W,
    parameter int unsigned SETS   = SA4_SETS,
    parameter int unsigned WAYS   = SA4_WAYS,
    parameter int unsigned OFF_W  = SA4_OFF_W,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [DATA_W-1:0] rsp_data
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [WAY_W-1:0]  way;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    // Storage: one valid flag, tag and word per way, one pointer per set.
    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [WAY_W-1:0]  rr_q    [SETS];

    // Address fields.
    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    logic             unused_off_bits;

    assign lk_idx = lk_addr[OFF_W +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign fl_idx = fill_addr[OFF_W +: IDX_W];
    assign fl_tag = fill_addr[ADDR_W-1 -: TAG_W];
    assign unused_off_bits = ^{lk_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

    // Lookup side: read the indexed set and compare every way.
    logic [WAYS-1:0]             lk_set_valid;
    logic [WAYS-1:0]             lk_match;
    logic [WAYS-1:0][DATA_W-1:0] lk_words;
    logic                        lk_hit;
    logic [WAY_W-1:0]            lk_hit_way;
    logic [DATA_W-1:0]           lk_hit_data;

    // Fill side: compare the fill tag against its own set.
    logic [WAYS-1:0]  fl_set_valid;
    logic [WAYS-1:0]  fl_match;
    logic             fl_hit;
    logic [WAY_W-1:0] fl_hit_way;
    logic [WAY_W-1:0] fl_rr;
    logic [WAY_W-1:0] fl_victim;
    logic             fl_from_rr;

    assign lk_set_valid = valid_q[lk_idx];
    assign fl_set_valid = valid_q[fl_idx];
    assign fl_rr        = rr_q[fl_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_words[w] = data_q[lk_idx][w];

        sa4_tag_cmp #(.TAG_W(TAG_W)) u_lk_cmp (
            .way_valid  (lk_set_valid[w]),
            .stored_tag (tag_q[lk_idx][w]),
            .probe_tag  (lk_tag),
            .match      (lk_match[w])
        );

        sa4_tag_cmp #(.TAG_W(TAG_W)) u_fl_cmp (
            .way_valid  (fl_set_valid[w]),
            .stored_tag (tag_q[fl_idx][w]),
            .probe_tag  (fl_tag),
            .match      (fl_match[w])
        );
    end

    sa4_way_sel #(.WAYS(WAYS), .DATA_W(DATA_W)) u_sel (
        .match    (lk_match),
        .way_data (lk_words),
        .hit      (lk_hit),
        .hit_way  (lk_hit_way),
        .hit_data (lk_hit_data)
    );

    sa4_victim #(.WAYS(WAYS)) u_victim (
        .set_valid (fl_set_valid),
        .rr_ptr    (fl_rr),
        .victim    (fl_victim),
        .from_rr   (fl_from_rr)
    );

    // Fill decision.
    logic             wr_en;
    logic [WAY_W-1:0] wr_way;
    logic             rr_adv;
    logic [WAY_W-1:0] rr_next;

    always_comb begin
        fl_hit     = |fl_match;
        fl_hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (fl_match[w]) begin
                fl_hit_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        wr_en   = fill_valid;
        wr_way  = fl_hit ? fl_hit_way : fl_victim;
        rr_adv  = fill_valid && !fl_hit && fl_from_rr;
        rr_next = fl_rr + WAY_W'(1);
    end

    // Next answer: reads the array as it stands before this edge's fill.
    always_comb begin
        rsp_d = '0;
        if (lk_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.hit   = lk_hit;
            if (lk_hit) begin
                rsp_d.way  = lk_hit_way;
                rsp_d.data = lk_hit_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            rsp_q <= rsp_d;
            if (wr_en) begin
                valid_q[fl_idx][wr_way] <= 1'b1;
            end
            if (rr_adv) begin
                rr_q[fl_idx] <= rr_next;
            end
        end
    end

    // Tag and word arrays need no reset: the valid flags gate them.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            tag_q[fl_idx][wr_way]  <= fl_tag;
            data_q[fl_idx][wr_way] <= fill_data;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_way   = rsp_q.way;
    assign rsp_data  = rsp_q.data;

endmodule

// File: rtl/sa4_lookup_chk.sv
module sa4_lookup_chk #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [WAYS-1:0]   lk_match,
    input logic              fill_valid,
    input logic [WAYS-1:0]   fl_set_valid,
    input logic              fl_hit,
    input logic [WAY_W-1:0]  fl_rr,
    input logic [WAY_W-1:0]  wr_way,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [DATA_W-1:0] rsp_data
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_way == '0 && rsp_data == '0));

    assert_free_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fl_hit && !(&fl_set_valid)) |-> !fl_set_valid[wr_way]);

    assert_rr_victim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fl_hit && (&fl_set_valid)) |-> (wr_way == fl_rr));

    assert_refill_resident_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fl_hit) |-> fl_set_valid[wr_way]);

    assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit));

endmodule

bind sa4_lookup sa4_lookup_chk #(.WAYS(WAYS), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_match     (lk_match),
    .fill_valid   (fill_valid),
    .fl_set_valid (fl_set_valid),
    .fl_hit       (fl_hit),
    .fl_rr        (fl_rr),
    .wr_way       (wr_way),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_way      (rsp_way),
    .rsp_data     (rsp_data)
);

// File: tb/sa4_lookup_tb.sv
module sa4_lookup_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_way;
    logic [31:0] rsp_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sa4_lookup u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_way    (rsp_way),
        .rsp_data   (rsp_data)
    );

    // Behavioural model: 256 sets x 4 ways, per-set pointer.
    bit          m_valid [256][4];
    logic [21:0] m_tag   [256][4];
    logic [31:0] m_data  [256][4];
    int          m_rr    [256];

    function automatic logic [31:0] mk(input logic [21:0] tag, input int idx, input int off);
        return {tag, 8'(idx), 2'(off)};
    endfunction

    task automatic check(input bit ok, input string rq, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One clock: drive, update model across the edge, compare at the falling edge.
    task automatic step(input bit lv, input logic [31:0] la, input bit fv,
                        input logic [31:0] fa, input logic [31:0] fd, input string rq);
        logic [35:0] exp;
        logic [35:0] act;
        int li;
        int fi;
        int wsel;
        lk_valid   = lv;
        lk_addr    = la;
        fill_valid = fv;
        fill_addr  = fa;
        fill_data  = fd;
        @(posedge clk);
        exp = '0;
        if (lv) begin
            li = int'(la[9:2]);
            exp[35] = 1'b1;
            for (int w = 0; w < 4; w++) begin
                if (m_valid[li][w] && m_tag[li][w] == la[31:10]) begin
                    exp[34]    = 1'b1;
                    exp[33:32] = 2'(w);
                    exp[31:0]  = m_data[li][w];
                end
            end
        end
        if (fv) begin
            fi = int'(fa[9:2]);
            wsel = -1;
            for (int w = 0; w < 4; w++) begin
                if (m_valid[fi][w] && m_tag[fi][w] == fa[31:10]) wsel = w;
            end
            if (wsel < 0) begin
                for (int w = 3; w >= 0; w--) begin
                    if (!m_valid[fi][w]) wsel = w;
                end
            end
            if (wsel < 0) begin
                wsel = m_rr[fi];
                m_rr[fi] = (m_rr[fi] + 1) % 4;
            end
            m_valid[fi][wsel] = 1'b1;
            m_tag[fi][wsel]   = fa[31:10];
            m_data[fi][wsel]  = fd;
        end
        @(negedge clk);
        act = {rsp_valid, rsp_hit, rsp_way, rsp_data};
        check(act === exp, rq, act, exp);
    endtask

    task automatic look(input logic [31:0] a, input string rq);
        step(1'b1, a, 1'b0, '0, '0, rq);
    endtask

    task automatic fill(input logic [31:0] a, input logic [31:0] d, input string rq);
        step(1'b0, '0, 1'b1, a, d, rq);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 256; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 1'b0;
                m_tag[s][w]   = '0;
                m_data[s][w]  = '0;
            end
        end
        // R1: answer quiet during reset
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R1", {35'd0, rsp_valid}, 36'd0);
        rst_n = 1'b1;

        // R1: empty after reset
        look(mk(22'h100, 5, 0), "R1");
        look(mk(22'h000, 0, 0), "R1");

        // R6: first fill takes way 0, R2 hit, R4 offset ignored
        fill(mk(22'h100, 5, 2), 32'hA000_0000, "R6");
        look(mk(22'h100, 5, 0), "R2");
        look(mk(22'h100, 5, 3), "R4");
        fill(mk(22'h101, 5, 1), 32'hA000_0001, "R6");
        fill(mk(22'h102, 5, 0), 32'hA000_0002, "R6");
        fill(mk(22'h103, 5, 3), 32'hA000_0003, "R6");
        look(mk(22'h103, 5, 0), "R2");
        look(mk(22'h101, 5, 2), "R4");

        // R7: full set, pointer victims 0 then 1
        fill(mk(22'h104, 5, 0), 32'hB000_0004, "R7");
        look(mk(22'h100, 5, 0), "R7");
        look(mk(22'h104, 5, 0), "R7");
        fill(mk(22'h105, 5, 0), 32'hB000_0005, "R7");
        look(mk(22'h101, 5, 0), "R7");
        look(mk(22'h105, 5, 0), "R7");

        // R8: resident tag rewritten in place, pointer unchanged
        fill(mk(22'h102, 5, 1), 32'hC000_0002, "R8");
        look(mk(22'h102, 5, 0), "R8");
        fill(mk(22'h106, 5, 0), 32'hC000_0006, "R8");
        look(mk(22'h106, 5, 0), "R8");

        // R7: a second set has its own pointer
        for (int k = 0; k < 5; k++) begin
            fill(mk(22'(22'h200 + k), 9, 0), 32'(32'hD000_0000 + k), "R7");
        end
        look(mk(22'h204, 9, 0), "R7");
        look(mk(22'h200, 9, 0), "R7");

        // R5: tag of set 5 does not hit elsewhere
        look(mk(22'h105, 6, 0), "R5");
        look(mk(22'h105, 4, 0), "R5");

        // R9: lookup and fill of the same address together
        step(1'b1, mk(22'h107, 5, 0), 1'b1, mk(22'h107, 5, 0), 32'hE000_0007, "R9");
        look(mk(22'h107, 5, 0), "R9");
        step(1'b1, mk(22'h106, 5, 0), 1'b1, mk(22'h106, 5, 0), 32'hE000_0016, "R9");
        look(mk(22'h106, 5, 0), "R9");

        // R11: idle cycle
        step(1'b0, mk(22'h107, 5, 0), 1'b0, '0, '0, "R11");

        // Mixed traffic on a small pool, R3 and R10 exercised by the model
        for (int n = 0; n < 600; n++) begin
            step(1'($urandom), mk(22'(22'h300 + $urandom % 7), 3 + $urandom % 2, $urandom % 4),
                 1'($urandom), mk(22'(22'h300 + $urandom % 7), 3 + $urandom % 2, $urandom % 4),
                 $urandom, "R3");
        end

        step(1'b0, '0, 1'b0, '0, '0, "R11");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule